// File: doc/BRIEF.md
# I2C Slave Register Port

This block is a slave on a two-wire serial bus. A host uses it to read and write a bank of byte-wide registers inside the chip. The block never drives the clock line. On the data line it either pulls low or lets go. Both lines pass through a two-flop synchroniser into the system clock domain, and every bus event is found on the synchronised copies. For that reason the system clock must run at least eight times faster than the serial clock.

A write transfer works as follows. The host sends a START and then the device address with the direction bit clear. The first data byte after that sets an internal register pointer. Each later byte is stored at the pointer, and the pointer then steps forward by one. To read, the host sets the pointer in a write transfer, issues a repeated START, and sends the address with the direction bit set. The block then sends the pointed register and steps the pointer after every byte the host acknowledges.

The lowest bit of the device address is a strap. The block takes it from the `addr_sel` pin on the cycle in which reset is released.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block only pulls SDA low (`sda_o` is 0 and `sda_oe` = 1 means pull low). `sda_oe` is 0 after reset and only becomes 1 while the synchronised SCL is low.
- R2: SDA falling while SCL is high is a START. It restarts address reception from any phase, repeated START included, with no STOP needed first.
- R3: SDA rising while SCL is high is a STOP. It returns the protocol engine to idle from any phase, and a partly received address byte is thrown away.
- R4: Bytes travel most significant bit first. The eighth bit is the last data bit and the ninth clock is the acknowledge slot.
- R5: The 7-bit device address is 0101010 if `addr_sel` was 0 at reset release, and 0101011 if it was 1. That gives write addresses 0x54 or 0x56 and read addresses 0x55 or 0x57. Changes on `addr_sel` after release have no effect.
- R6: On an address match the block pulls SDA low in the ninth clock. On a mismatch it leaves SDA high and stays off the bus until the next START, so later bytes get no acknowledge either.
- R7: In a write transfer, the first data byte loads the register pointer. Each following byte is written to the pointed register, and the pointer then increments, wrapping from 0xFF to 0x00. Every received byte is acknowledged.
- R8: In a read transfer, the block returns the register at the pointer. The pointer increments after each byte that the host acknowledges (SDA low in the ninth clock).
- R9: If the host leaves SDA high in the ninth clock of a read byte (NACK), the block stops sending. It keeps SDA released until the next START, so further clocked bits read as 1.
- R10: Reset clears every register to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap for the device address LSB, taken on reset release |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_o | output | 1 | Level driven while enabled (always 0) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest situations to reach are those where the bus is cut off part-way through. These include a STOP that lands in the middle of an address byte, a repeated START that arrives while the engine is in write-data phase, and a host NACK followed by more clocks that the slave must ignore. The stimulus builds each of these from bit-level master tasks (single bits, START and STOP), so a transfer can be broken off at any bit. A fresh, full transfer follows each one to show the engine came back to a clean state. A second reset with the strap flipped shows the address change and the register clear.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_AW = 7;

    // upper six bits of the device address; the strap supplies the LSB
    localparam logic [DEV_AW-2:0] DEV_ADDR_HI = 6'b010101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_DRV,
        ST_ACK_HOLD,
        ST_WR,
        ST_RD,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_WAIT
    } i2cs_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] first_byte,
                                       input logic strap);
        return first_byte[BYTE_W-1:1] == {DEV_ADDR_HI, strap};
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_s
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_p;
    logic              sda_p;
    logic              sda_s;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
    import i2cs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     reg_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_en,
    output logic              sda_oe,
    output i2cs_state_e       state
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] byte_in;
    logic [AW-1:0]     ptr;
    logic [AW-1:0]     wr_addr;
    logic              rw;
    logic              ptr_set;

    assign byte_in  = {sh[BYTE_W-2:0], ev.sda};
    assign reg_addr = wr_en ? wr_addr : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            sh      <= '0;
            tx      <= '0;
            ptr     <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_en   <= 1'b0;
            rw      <= 1'b0;
            ptr_set <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: if (ev.scl_rise) begin
                        sh     <= byte_in;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            if (dev_match(byte_in, strap)) begin
                                rw    <= byte_in[0];
                                state <= ST_ACK_DRV;
                                if (!byte_in[0]) ptr_set <= 1'b0;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_ACK_DRV: if (ev.scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK_HOLD;
                    end
                    ST_ACK_HOLD: if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                    ST_WR: if (ev.scl_rise) begin
                        sh     <= byte_in;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            state  <= ST_ACK_DRV;
                            if (!ptr_set) begin
                                ptr     <= byte_in[AW-1:0];
                                ptr_set <= 1'b1;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= byte_in;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_RD: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == ALL_BITS) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: if (ev.scl_rise) begin
                        if (!ev.sda) begin
                            ptr   <= ptr + 1'b1;
                            state <= ST_RD_NEXT;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                    ST_RD_NEXT: if (ev.scl_fall) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        bitcnt <= '0;
                        state  <= ST_RD;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2cs_pkg::*;
#(
    parameter int REG_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic addr_sel,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic sda_oe
);

    bus_ev_t           ev;
    logic              scl_s;
    logic              ev_start;
    logic              ev_stop;
    logic              rst_q;
    logic              dev_lsb;
    logic [REG_AW-1:0] reg_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    i2cs_state_e       eng_state;

    assign sda_o    = 1'b0;
    assign ev_start = ev.start;
    assign ev_stop  = ev.stop;

    // address strap captured on the cycle reset is released
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) dev_lsb <= addr_sel;
    end

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev),
        .scl_s (scl_s)
    );

    i2cs_engine #(.AW(REG_AW)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .strap    (dev_lsb),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .sda_oe   (sda_oe),
        .state    (eng_state)
    );

    i2cs_regfile #(.AW(REG_AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wdata (wr_data),
        .we    (wr_en),
        .rdata (rd_data)
    );

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
    import i2cs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        scl_s,
    input logic        ev_start,
    input logic        ev_stop,
    input logic        sda_oe,
    input logic        wr_en,
    input logic        rst_q,
    input logic        dev_lsb,
    input i2cs_state_e eng_state
);

    // R1
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R1
    oe_reset_chk: assert property (@(posedge clk)
        rst |=> !sda_oe);

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> eng_state == ST_IDLE);

    // R2
    start_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_start && !ev_stop) |=> eng_state == ST_ADDR);

    // R7
    wr_ack_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> eng_state == ST_ACK_DRV);

    // R5
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst_q) |-> $stable(dev_lsb));

    // R9
    off_bus_chk: assert property (@(posedge clk) disable iff (rst)
        eng_state == ST_WAIT |-> !sda_oe);

endmodule

bind i2c_reg_slave i2cs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .rst_q     (rst_q),
    .dev_lsb   (dev_lsb),
    .eng_state (eng_state)
);

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_sel = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_o;
    logic sda_oe;
    logic sda_line;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } item_t;

    item_t exp_q[$];
    logic [7:0] act_q[$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~(sda_oe & ~sda_o);

    i2c_reg_slave uut (
        .clk      (clk),
        .rst      (rst),
        .addr_sel (addr_sel),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe)
    );

    // scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e;
            logic [7:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_run++;
            if (a !== e.val) begin
                n_fail++;
                $display("FAIL %s: actual %02h expected %02h", e.req, a, e.val);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        scl_m = 1'b1;
        sda_m = 1'b1;
        addr_sel = strap;
        tick(4);
        rst = 1'b0;
        tick(3);
        n_run++;
        if (sda_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual sda_oe %0b expected 0 after reset", sda_oe);
        end
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // send a byte, expected ack slot level: 0 = ack, 1 = nack
    task automatic m_wbyte(input logic [7:0] v, input logic exp_ack, input string req);
        logic a;
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(a);
        exp_q.push_back('{val: {7'd0, exp_ack}, req: req});
        act_q.push_back({7'd0, a});
    endtask

    task automatic m_rbyte(input logic [7:0] exp_v, input logic nack, input string req);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            v[i] = b;
        end
        m_wbit(nack);
        exp_q.push_back('{val: exp_v, req: req});
        act_q.push_back(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b0);

        // R10: register 0x00 reads zero after reset
        m_start();
        m_wbyte(8'h54, 1'b0, "R6");
        m_wbyte(8'h00, 1'b0, "R7");
        m_start();
        m_wbyte(8'h55, 1'b0, "R2");
        m_rbyte(8'h00, 1'b1, "R10");
        m_stop();

        // R7: pointer then three data bytes
        m_start();
        m_wbyte(8'h54, 1'b0, "R6");
        m_wbyte(8'h10, 1'b0, "R7");
        m_wbyte(8'hA5, 1'b0, "R7");
        m_wbyte(8'h3C, 1'b0, "R7");
        m_wbyte(8'h81, 1'b0, "R7");
        m_stop();

        // R5: strap change after release ignored
        addr_sel = 1'b1;
        tick(4);

        // R8 R4 R2: read back through repeated START
        m_start();
        m_wbyte(8'h54, 1'b0, "R5");
        m_wbyte(8'h10, 1'b0, "R7");
        m_start();
        m_wbyte(8'h55, 1'b0, "R2");
        m_rbyte(8'hA5, 1'b0, "R8");
        m_rbyte(8'h3C, 1'b0, "R4");
        m_rbyte(8'h81, 1'b1, "R8");
        // R9: after NACK the slave stays released
        m_rbyte(8'hFF, 1'b1, "R9");
        m_stop();

        // R6: foreign address is not acknowledged, nor is a later byte
        m_start();
        m_wbyte(8'h56, 1'b1, "R6");
        m_wbyte(8'h00, 1'b1, "R6");
        m_stop();

        // R3: STOP in the middle of the address byte
        m_start();
        m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1);
        m_stop();
        m_start();
        m_wbyte(8'h54, 1'b0, "R3");
        m_wbyte(8'hFF, 1'b0, "R7");
        m_wbyte(8'h11, 1'b0, "R7");
        m_wbyte(8'h22, 1'b0, "R7");
        // R2: repeated START straight out of write-data phase
        m_start();
        m_wbyte(8'h54, 1'b0, "R2");
        m_wbyte(8'hFF, 1'b0, "R7");
        m_start();
        m_wbyte(8'h55, 1'b0, "R2");
        m_rbyte(8'h11, 1'b0, "R7");
        m_rbyte(8'h22, 1'b1, "R7");
        m_stop();

        // R5 R10: new strap value at a fresh reset
        do_reset(1'b1);
        m_start();
        m_wbyte(8'h54, 1'b1, "R5");
        m_stop();
        m_start();
        m_wbyte(8'h56, 1'b0, "R5");
        m_wbyte(8'h10, 1'b0, "R7");
        m_start();
        m_wbyte(8'h57, 1'b0, "R5");
        m_rbyte(8'h00, 1'b1, "R10");
        m_stop();

        tick(8);
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule